// File: doc/BRIEF.md
# Buffered Synchronous Serial Transmitter

This block sends 8-bit words over a serial line that is clocked by an external bit clock. A host hands words to the block through a valid/ready write port. Each accepted word waits in a one-word holding register. When a frame pulse arrives, the word moves into a shift register and is sent most significant bit first. A programmable delay of zero, one or two bit periods can be placed between the frame pulse and the first bit. The line is driven on rising bit-clock edges, so a receiver can sample it on falling edges.

The bit clock and the frame pulse are brought into the system clock domain through a synchronizer, and the block acts on their edges. The write port may accept a new word as soon as the previous word has moved into the shift register. This two-stage buffering lets the host load the next word while the current one is being sent. The ready signal comes back high on the bit-clock falling edge after that move. A frame pulse that finds no new word causes the last word to be sent again, and a sticky underflow flag is raised.

Back-pressure rules for the write port: a word is taken on a system clock edge where `wr_valid` and `wr_ready` are both high. The host keeps `wr_valid` and `wr_data` steady until that happens. While `wr_ready` is low nothing is taken, and the holding register is left as it was.

Top module: `ser_tx_buf`

## Requirements
- R1: After reset, `wr_ready` is 1, `sdata` is 0 and `underflow` is 0.
- R2: A word is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. From the next clock, `wr_ready` is 0, and it stays 0 until the word has moved into the shift register.
- R3: The move from holding register to shift register happens on the bit-clock falling edge where a high `fsync` is first seen while idle. `wr_ready` goes back to 1 on the next falling edge, and not before it.
- R4: An element is 8 bits sent most significant bit first. Each bit is driven on one rising edge of `sclk` and holds for a full bit period. `sdata` changes only after a rising edge.
- R5: Let d be the value of `dly_sel` when the frame is detected (0, 1 or 2). The MSB is driven on rising edge d+1 after the detecting falling edge, and `sdata` stays 0 on the d rising edges before it.
- R6: `sdata` is 0 whenever no element is being sent. It returns to 0 on the rising edge that ends the LSB's period.
- R7: If a frame is detected while the holding register is empty, the last word moved into the shift register is sent again. `underflow` is then set and stays 1 until reset.
- R8: A high `fsync` seen while a delay or an element is in progress has no effect.
- R9: While `wr_ready` is 0, a write attempt is not accepted, and the word already in the holding register is the one sent next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | External bit clock, asynchronous, synchronized internally |
| fsync | input | 1 | Frame pulse, sampled on falling bit-clock edges |
| dly_sel | input | DLY_W | Bit periods between frame detection and the MSB (0 to 2) |
| wr_valid | input | 1 | Host offers a word |
| wr_data | input | DATA_W | Word offered by the host |
| wr_ready | output | 1 | Holding register can take a word |
| sdata | output | 1 | Serial data line |
| underflow | output | 1 | Sticky flag: a frame found no new word |

## Verification
The bench uses the default parameters: 8-bit words, a 2-bit delay field and a two-stage synchronizer. It runs the bit clock at twelve system clocks per period, which is slow enough for every synchronizer and register delay to settle within half a bit period. With these values the bench can reach all three delay settings, the ready timing around the move on the falling edge, the resend on underflow, a frame pulse held through an element, and a write that is blocked while the holding register is full.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_DELAY = 2'd1,
    TX_SHIFT = 2'd2
  } tx_state_e;
endpackage

// File: rtl/tx_edge_sync.sv
// Brings the bit clock and frame pulse into the system clock domain and
// produces single-cycle rise/fall events of the bit clock.
module tx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic fs_in,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic fs_q
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] sck_chain;
  logic [TOP:0] fs_chain;
  logic         sck_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_chain <= '0;
      fs_chain  <= '0;
      sck_prev  <= 1'b0;
    end else begin
      sck_chain <= {sck_chain[TOP-1:0], sclk_in};
      fs_chain  <= {fs_chain[TOP-1:0], fs_in};
      sck_prev  <= sck_chain[TOP];
    end
  end

  assign sclk_rise = sck_chain[TOP] & ~sck_prev;
  assign sclk_fall = ~sck_chain[TOP] & sck_prev;
  assign fs_q      = fs_chain[TOP];
endmodule

// File: rtl/tx_holdreg.sv
// One-word holding register with the host-side ready flag and the
// underflow record.
module tx_holdreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         start,
  input  logic         sclk_fall,
  output logic         wr_ready,
  output logic [W-1:0] word,
  output logic         underflow
);
  logic [W-1:0] hold_q;
  logic [W-1:0] last_q;
  logic         full_q;
  logic         pend_q;
  logic         accept;

  assign accept = wr_valid & wr_ready;
  assign word   = full_q ? hold_q : last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '0;
      last_q    <= '0;
      full_q    <= 1'b0;
      pend_q    <= 1'b0;
      wr_ready  <= 1'b1;
      underflow <= 1'b0;
    end else begin
      if (start) begin
        if (full_q) begin
          last_q <= hold_q;
          full_q <= 1'b0;
          pend_q <= 1'b1;
        end else begin
          underflow <= 1'b1;
        end
      end else if (sclk_fall && pend_q) begin
        wr_ready <= 1'b1;
        pend_q   <= 1'b0;
      end
      if (accept) begin
        hold_q   <= wr_data;
        full_q   <= 1'b1;
        wr_ready <= 1'b0;
      end
    end
  end

  assert_ready_excl_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !full_q);
  assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !wr_ready);
  assert_ready_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_ready) |-> $past(sclk_fall));
  assert_underflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  assert_blocked_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> $stable(hold_q));
endmodule

// File: rtl/tx_shifter.sv
// Frame detection, data delay and MSB-first shifting.
module tx_shifter
  import ser_tx_pkg::*;
#(
  parameter int W     = 8,
  parameter int DLY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             fs_q,
  input  logic [DLY_W-1:0] dly_sel,
  input  logic [W-1:0]     word,
  output logic             start,
  output logic             sdata
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W);

  tx_state_e        state;
  logic [W-1:0]     sreg;
  logic [DLY_W-1:0] dly_cnt;
  logic [CNT_W-1:0] bit_cnt;

  assign start = sclk_fall & fs_q & (state == TX_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= TX_IDLE;
      sreg    <= '0;
      dly_cnt <= '0;
      bit_cnt <= '0;
      sdata   <= 1'b0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (start) begin
            sreg    <= word;
            dly_cnt <= dly_sel;
            state   <= TX_DELAY;
          end
        end
        TX_DELAY: begin
          if (sclk_rise) begin
            if (dly_cnt == '0) begin
              sdata   <= sreg[W-1];
              sreg    <= {sreg[W-2:0], 1'b0};
              bit_cnt <= CNT_W'(1);
              state   <= TX_SHIFT;
            end else begin
              dly_cnt <= dly_cnt - 1'b1;
            end
          end
        end
        TX_SHIFT: begin
          if (sclk_rise) begin
            if (bit_cnt == LAST) begin
              sdata <= 1'b0;
              state <= TX_IDLE;
            end else begin
              sdata   <= sreg[W-1];
              sreg    <= {sreg[W-2:0], 1'b0};
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assert_idle_line_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_IDLE) |-> !sdata);
  assert_change_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> $past(sclk_rise));
  assert_delay_line_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_DELAY) |-> !sdata);
endmodule

// File: rtl/ser_tx_buf.sv
module ser_tx_buf #(
  parameter int DATA_W      = 8,
  parameter int DLY_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              fsync,
  input  logic [DLY_W-1:0]  dly_sel,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              sdata,
  output logic              underflow
);
  logic              sclk_rise;
  logic              sclk_fall;
  logic              fs_q;
  logic              start;
  logic [DATA_W-1:0] word;

  tx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .fs_in(fsync),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .fs_q(fs_q)
  );

  tx_holdreg #(.W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .start(start), .sclk_fall(sclk_fall), .wr_ready(wr_ready),
    .word(word), .underflow(underflow)
  );

  tx_shifter #(.W(DATA_W), .DLY_W(DLY_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .fs_q(fs_q), .dly_sel(dly_sel), .word(word), .start(start), .sdata(sdata)
  );

  assert_start_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (sclk_fall && fs_q));
endmodule

// File: tb/ser_tx_buf_test.sv
module ser_tx_buf_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       fsync = 1'b0;
  logic [1:0] dly_sel = 2'd0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ready;
  logic       sdata;
  logic       underflow;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ser_tx_buf uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync(fsync), .dly_sel(dly_sel),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .sdata(sdata), .underflow(underflow)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic half_bit();
    repeat (6) @(negedge clk);
  endtask

  task automatic bit_rise();
    sclk = 1'b1;
    half_bit();
  endtask

  task automatic bit_fall(output logic s);
    s = sdata;
    sclk = 1'b0;
    half_bit();
  endtask

  task automatic write_word(input logic [7:0] w);
    int t = 0;
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = w;
    while (!wr_ready && t < 200) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk);
    wr_valid = 1'b0;
    check(wr_ready == 1'b0, "R2", "ready after accept", 32'(wr_ready), 32'd0);
  endtask

  // Frame with delay d; expects word w, 0 in the delay and after the element.
  task automatic run_frame(input int d, input logic [7:0] w, input bit chk_rdy,
                           input bit hold_fs, input string req);
    logic [15:0] got = '0;
    logic [15:0] exp = '0;
    logic s;
    dly_sel = 2'(d);
    fsync = 1'b1;
    bit_rise();
    bit_fall(s);
    if (!hold_fs) fsync = 1'b0;
    for (int i = 1; i <= d + 11; i++) begin
      if (hold_fs && i == 5) fsync = 1'b0;
      bit_rise();
      if (chk_rdy && i == 1)
        check(wr_ready == 1'b0, "R3", "ready before next fall", 32'(wr_ready), 32'd0);
      bit_fall(s);
      got[i-1] = s;
      if (chk_rdy && i == 1)
        check(wr_ready == 1'b1, "R3", "ready after next fall", 32'(wr_ready), 32'd1);
      if (i > d && i <= d + 8) exp[i-1] = w[7-(i-d-1)];
    end
    check(got == exp, req, "serial samples", 32'(got), 32'(exp));
  endtask

  task automatic t_reset();
    check(wr_ready == 1'b1, "R1", "ready at reset", 32'(wr_ready), 32'd1);
    check(sdata == 1'b0, "R1", "sdata at reset", 32'(sdata), 32'd0);
    check(underflow == 1'b0, "R1", "underflow at reset", 32'(underflow), 32'd0);
  endtask

  task automatic t_basic();
    write_word(8'hA5);
    run_frame(0, 8'hA5, 1'b1, 1'b0, "R4");
  endtask

  task automatic t_delays();
    write_word(8'h3C);
    run_frame(1, 8'h3C, 1'b1, 1'b0, "R5");
    write_word(8'h81);
    run_frame(2, 8'h81, 1'b1, 1'b0, "R5");
  endtask

  task automatic t_underflow();
    check(underflow == 1'b0, "R7", "no underflow yet", 32'(underflow), 32'd0);
    run_frame(0, 8'h81, 1'b0, 1'b0, "R7");
    check(underflow == 1'b1, "R7", "underflow set", 32'(underflow), 32'd1);
    check(wr_ready == 1'b1, "R7", "ready kept", 32'(wr_ready), 32'd1);
  endtask

  task automatic t_blocked();
    write_word(8'hC3);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = 8'h0F;
    repeat (20) @(negedge clk);
    check(wr_ready == 1'b0, "R9", "ready held low", 32'(wr_ready), 32'd0);
    wr_valid = 1'b0;
    run_frame(0, 8'hC3, 1'b1, 1'b0, "R9");
  endtask

  task automatic t_fs_held();
    logic s;
    write_word(8'h5A);
    run_frame(1, 8'h5A, 1'b1, 1'b1, "R8");
    for (int i = 0; i < 3; i++) begin
      bit_rise();
      bit_fall(s);
      check(s == 1'b0, "R6", "idle line", 32'(s), 32'd0);
    end
    check(underflow == 1'b1, "R7", "underflow sticky", 32'(underflow), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_delays();
    t_underflow();
    t_blocked();
    t_fs_held();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule